// File: doc/BRIEF.md
# Accumulator Scaling Shifter with Exponent Encoder

The block scales a 40-bit accumulator word in a single clock. A signed shift count moves the word left (positive) or right (negative). Zeros always enter at the low end. On a right shift, the bits that enter at the high end are either zeros or copies of the sign bit, as a sign-extension-mode input chooses. The count comes from one of three places: an immediate operand, a field of a status register, or the low bits of a 16-bit temporary register that the block keeps itself.

Next to the shifter sits an exponent encoder. It counts how many bits below the most significant bit repeat that bit, which are the redundant sign bits. When an exponent strobe is raised, that count is written into the temporary register. A following shift that takes its count from the temporary register then normalizes the value in one step. The temporary register can also be loaded directly.

All outputs are registered, so each result appears one clock after its inputs were presented.

Top module: `acc_scaler`

## Requirements
- R1: While `rst` is high at a clock edge, `result`, `exp_val` and `t_val` are cleared to zero at that edge.
- R2: A positive count c shifts `data_in` left by c places. Zeros fill the low bits, and bits moved beyond bit 39 are lost. A count of zero passes the word unchanged.
- R3: A negative count -c shifts right by c places. The high bits are filled with copies of bit 39 when `sxm`=1 and with zeros when `sxm`=0.
- R4: The count is a 6-bit two's-complement value (range -32 to +31). Any count below -16 acts as -16, and left shifts are limited to 31 places.
- R5: `cnt_sel` picks the count source: 2'b00 takes `imm_cnt`, 2'b01 takes `stat_cnt`, 2'b10 takes bits [5:0] of the temporary register, and 2'b11 applies a count of zero.
- R6: `exp_val` is the number of consecutive bits, starting at bit 38 and going down, that equal bit 39. An all-zero or all-one word gives 39.
- R7: When `exp_strobe` is high, the exponent of the current `data_in` is written, zero-extended, into the temporary register. Otherwise, `t_load` writes `t_din` into it. With neither high, it holds its value. The strobe wins over `t_load`.
- R8: `result` and `exp_val` reflect the inputs sampled at the previous clock edge, which is one cycle of latency. A shift that reads the temporary register uses its value from before that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 40 | Accumulator word to shift and encode |
| imm_cnt | input | 6 | Immediate shift count, two's complement |
| stat_cnt | input | 6 | Status-register shift count, two's complement |
| cnt_sel | input | 2 | Count source select |
| sxm | input | 1 | Sign-extension mode for right shifts |
| exp_strobe | input | 1 | Write the exponent into the temporary register |
| t_load | input | 1 | Load `t_din` into the temporary register |
| t_din | input | 16 | Direct load value for the temporary register |
| result | output | 40 | Shifted word, registered |
| exp_val | output | 6 | Redundant sign bit count, registered |
| t_val | output | 16 | Temporary register contents |

## Verification
The bench builds the block with its default parameters: a 40-bit word, a 6-bit count, a 16-bit temporary register, and limits of 31 places left and 16 places right. With a 6-bit count, the right-shift clamp is reachable through counts from -17 down to -32. The left limit equals the largest positive count, so the left clamp cannot be exercised at these values. Exponents can reach their full span from 0 to 39, which covers the all-zero and all-one words. Storing an exponent and then shifting by the temporary register shows one-step normalization end to end.

// File: rtl/acs_pkg.sv
package acs_pkg;
  typedef enum logic [1:0] {
    SRC_IMM  = 2'b00,
    SRC_STAT = 2'b01,
    SRC_TREG = 2'b10,
    SRC_NONE = 2'b11
  } cnt_src_e;
endpackage

// File: rtl/acs_count_sel.sv
module acs_count_sel #(
  parameter int CW   = 6,
  parameter int TW   = 16,
  parameter int LMAX = 31,
  parameter int RMAX = 16,
  parameter int SW   = 5
) (
  input  logic [CW-1:0] imm_cnt,
  input  logic [CW-1:0] stat_cnt,
  input  logic [TW-1:0] t_reg,
  input  logic [1:0]    cnt_sel,
  output logic          go_left,
  output logic [SW-1:0] amt
);
  import acs_pkg::*;

  logic [CW-1:0] raw;
  cnt_src_e      src;
  int            c;
  int            mag;

  assign src = cnt_src_e'(cnt_sel);

  always_comb begin
    unique case (src)
      SRC_IMM:  raw = imm_cnt;
      SRC_STAT: raw = stat_cnt;
      SRC_TREG: raw = t_reg[CW-1:0];
      default:  raw = '0;
    endcase
  end

  // Signed count, clamped to the asymmetric limits
  always_comb begin
    c = int'($signed(raw));
    if (c >= 0) begin
      go_left = 1'b1;
      mag     = (c > LMAX) ? LMAX : c;
    end else begin
      go_left = 1'b0;
      mag     = (-c > RMAX) ? RMAX : -c;
    end
    amt = mag[SW-1:0];
  end
endmodule

// File: rtl/acs_barrel.sv
module acs_barrel #(
  parameter int DW = 40,
  parameter int SW = 5
) (
  input  logic [DW-1:0] din,
  input  logic          go_left,
  input  logic [SW-1:0] amt,
  input  logic          sxm,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] stage [SW+1];
  logic          fill;

  assign fill     = sxm & din[DW-1];
  assign stage[0] = din;

  // Logarithmic stages: stage s moves the word by 2**s places
  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int SH = 1 << s;
    logic [DW-1:0] lft, rgt;
    assign lft = {stage[s][DW-1-SH:0], {SH{1'b0}}};
    assign rgt = {{SH{fill}}, stage[s][DW-1:SH]};
    assign stage[s+1] = amt[s] ? (go_left ? lft : rgt) : stage[s];
  end

  assign dout = stage[SW];
endmodule

// File: rtl/acs_expenc.sv
module acs_expenc #(
  parameter int DW = 40,
  parameter int EW = 6
) (
  input  logic [DW-1:0] din,
  output logic [EW-1:0] expo
);
  logic [DW-2:0] same;
  int            cnt;
  logic          run;

  // Bit i is 1 when it repeats the sign bit
  for (genvar i = 0; i < DW-1; i++) begin : g_same
    assign same[i] = ~(din[i] ^ din[DW-1]);
  end

  always_comb begin
    cnt = 0;
    run = 1'b1;
    for (int i = DW-2; i >= 0; i--) begin
      if (run && same[i]) cnt = cnt + 1;
      else                run = 1'b0;
    end
    expo = cnt[EW-1:0];
  end
endmodule

// File: rtl/acc_scaler.sv
module acc_scaler #(
  parameter int DW   = 40,
  parameter int CW   = 6,
  parameter int TW   = 16,
  parameter int LMAX = 31,
  parameter int RMAX = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] data_in,
  input  logic [CW-1:0] imm_cnt,
  input  logic [CW-1:0] stat_cnt,
  input  logic [1:0]    cnt_sel,
  input  logic          sxm,
  input  logic          exp_strobe,
  input  logic          t_load,
  input  logic [TW-1:0] t_din,
  output logic [DW-1:0] result,
  output logic [5:0]    exp_val,
  output logic [TW-1:0] t_val
);
  localparam int SW = $clog2(((LMAX > RMAX) ? LMAX : RMAX) + 1);
  localparam int EW = $clog2(DW);

  logic          go_left;
  logic [SW-1:0] amt;
  logic [DW-1:0] shifted;
  logic [EW-1:0] expo;
  logic [TW-1:0] t_reg;

  acs_count_sel #(.CW(CW), .TW(TW), .LMAX(LMAX), .RMAX(RMAX), .SW(SW)) u_cnt (
    .imm_cnt (imm_cnt),
    .stat_cnt(stat_cnt),
    .t_reg   (t_reg),
    .cnt_sel (cnt_sel),
    .go_left (go_left),
    .amt     (amt)
  );

  acs_barrel #(.DW(DW), .SW(SW)) u_bsh (
    .din    (data_in),
    .go_left(go_left),
    .amt    (amt),
    .sxm    (sxm),
    .dout   (shifted)
  );

  acs_expenc #(.DW(DW), .EW(EW)) u_exp (
    .din (data_in),
    .expo(expo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      exp_val <= '0;
      t_reg   <= '0;
    end else begin
      result  <= shifted;
      exp_val <= 6'(expo);
      if (exp_strobe)  t_reg <= TW'(expo);
      else if (t_load) t_reg <= t_din;
    end
  end

  assign t_val = t_reg;
endmodule

// File: rtl/acs_chk.sv
module acs_chk #(
  parameter int DW = 40,
  parameter int CW = 6,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] data_in,
  input logic [CW-1:0] imm_cnt,
  input logic [1:0]    cnt_sel,
  input logic          sxm,
  input logic          exp_strobe,
  input logic          t_load,
  input logic [DW-1:0] result,
  input logic [5:0]    exp_val,
  input logic [TW-1:0] t_val
);
  logic live;
  always_ff @(posedge clk) live <= !rst;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && exp_val == '0 && t_val == '0));

  // R2
  zero_count_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_sel == 2'b00 && imm_cnt == '0) |=> result == $past(data_in));

  // R2
  left_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_sel == 2'b00 && !imm_cnt[CW-1] && imm_cnt != '0) |=> !result[0]);

  // R3
  sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_sel == 2'b00 && imm_cnt[CW-1] && sxm && data_in[DW-1]) |=> result[DW-1]);

  // R3
  zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_sel == 2'b00 && imm_cnt[CW-1] && !sxm) |=> !result[DW-1]);

  // R6
  exp_range_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> exp_val <= 6'(DW-1));

  // R6
  exp_all_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (data_in == '0) |=> exp_val == 6'(DW-1));

  // R7
  t_store_chk: assert property (@(posedge clk) disable iff (rst)
    exp_strobe |=> t_val == TW'(exp_val));

  // R7
  t_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live && !exp_strobe && !t_load) |=> $stable(t_val));
endmodule

bind acc_scaler acs_chk #(.DW(DW), .CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .data_in(data_in), .imm_cnt(imm_cnt),
  .cnt_sel(cnt_sel), .sxm(sxm), .exp_strobe(exp_strobe), .t_load(t_load),
  .result(result), .exp_val(exp_val), .t_val(t_val)
);

// File: tb/acc_scaler_tb.sv
module acc_scaler_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] data_in = '0;
  logic [5:0]  imm_cnt = '0, stat_cnt = '0;
  logic [1:0]  cnt_sel = 2'b00;
  logic        sxm = 1'b0, exp_strobe = 1'b0, t_load = 1'b0;
  logic [15:0] t_din = '0;
  logic [39:0] result;
  logic [5:0]  exp_val;
  logic [15:0] t_val;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  acc_scaler u_dut (
    .clk(clk), .rst(rst), .data_in(data_in), .imm_cnt(imm_cnt),
    .stat_cnt(stat_cnt), .cnt_sel(cnt_sel), .sxm(sxm),
    .exp_strobe(exp_strobe), .t_load(t_load), .t_din(t_din),
    .result(result), .exp_val(exp_val), .t_val(t_val)
  );

  function automatic logic [39:0] m_shift(logic [39:0] d, logic [5:0] cnt, logic s);
    int c = int'($signed(cnt));
    if (c < -16) c = -16;
    if (c >= 0) return d << c;
    if (s) return 40'($signed(d) >>> (-c));
    return d >> (-c);
  endfunction

  function automatic logic [5:0] m_exp(logic [39:0] d);
    int n = 0;
    for (int i = 38; i >= 0; i--) begin
      if (d[i] != d[39]) break;
      n++;
    end
    return 6'(n);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic shift_case(input string req, input logic [39:0] d,
                            input logic [5:0] c, input logic s);
    data_in = d; imm_cnt = c; cnt_sel = 2'b00; sxm = s;
    step();
    chk(result === m_shift(d, c, s), req, result, m_shift(d, c, s));
  endtask

  task automatic exp_case(input logic [39:0] d, input logic [5:0] e);
    data_in = d;
    step();
    chk(exp_val === e, "R6 exponent", 40'(exp_val), 40'(e));
  endtask

  task automatic t_reset();
    repeat (3) step();
    chk(result === '0, "R1 result", result, '0);
    chk(exp_val === '0, "R1 exp", 40'(exp_val), '0);
    chk(t_val === '0, "R1 t", 40'(t_val), '0);
    rst = 1'b0;
  endtask

  task automatic t_left();
    shift_case("R2 left 4", 40'h00_1234_5678, 6'd4, 1'b0);
    shift_case("R2 left 31 overflow", 40'hFF_FFFF_FFFF, 6'd31, 1'b1);
    shift_case("R2 zero count", 40'h9A_BCDE_F012, 6'd0, 1'b1);
    chk(result === 40'h9A_BCDE_F012, "R2 pass", result, 40'h9A_BCDE_F012);
  endtask

  task automatic t_right();
    shift_case("R3 sign fill", 40'h80_0000_0000, 6'h30, 1'b1);
    chk(result === 40'hFF_FF80_0000, "R3 sign fill value", result, 40'hFF_FF80_0000);
    shift_case("R3 zero fill", 40'h80_0000_0000, 6'h30, 1'b0);
    chk(result === 40'h00_0080_0000, "R3 zero fill value", result, 40'h00_0080_0000);
    shift_case("R3 right 1 positive", 40'h40_0000_0003, 6'h3F, 1'b1);
  endtask

  task automatic t_clamp();
    shift_case("R4 clamp -32", 40'hC3_1234_5678, 6'h20, 1'b1);
    chk(result === m_shift(40'hC3_1234_5678, 6'h30, 1'b1), "R4 -32 equals -16",
        result, m_shift(40'hC3_1234_5678, 6'h30, 1'b1));
    shift_case("R4 clamp -17", 40'hC3_1234_5678, 6'h2F, 1'b0);
  endtask

  task automatic t_sources();
    data_in = 40'h00_0000_0F0F; imm_cnt = 6'd1; stat_cnt = 6'd3; cnt_sel = 2'b01; sxm = 1'b0;
    step();
    chk(result === 40'h00_0000_7878, "R5 status source", result, 40'h00_0000_7878);
    t_din = 16'h003B; t_load = 1'b1; cnt_sel = 2'b11;
    step();
    t_load = 1'b0;
    chk(result === 40'h00_0000_0F0F, "R5 none source", result, 40'h00_0000_0F0F);
    cnt_sel = 2'b10;
    step();
    chk(result === 40'h00_0000_0078, "R5 t source -5", result, 40'h00_0000_0078);
  endtask

  task automatic t_exponent();
    exp_case(40'h00_0000_0000, 6'd39);
    exp_case(40'hFF_FFFF_FFFF, 6'd39);
    exp_case(40'h00_0000_0001, 6'd38);
    exp_case(40'h40_0000_0000, 6'd0);
    exp_case(40'hC0_0000_0000, 6'd1);
    exp_case(40'h12_3456_789A, m_exp(40'h12_3456_789A));
  endtask

  task automatic t_tstore();
    cnt_sel = 2'b11;
    data_in = 40'h00_0000_FFFF; exp_strobe = 1'b1; t_load = 1'b1; t_din = 16'hABCD;
    step();
    exp_strobe = 1'b0; t_load = 1'b0;
    chk(t_val === 16'd23, "R7 strobe wins", 40'(t_val), 40'd23);
    data_in = 40'h00_0000_0001;
    step();
    chk(t_val === 16'd23, "R7 hold", 40'(t_val), 40'd23);
    data_in = 40'h00_0000_FFFF; cnt_sel = 2'b10;
    step();
    chk(result === 40'h7F_FF80_0000, "R8 normalize via T", result, 40'h7F_FF80_0000);
    t_load = 1'b1; t_din = 16'h1234; cnt_sel = 2'b10;
    step();
    t_load = 1'b0;
    chk(t_val === 16'h1234, "R7 load", 40'(t_val), 40'h1234);
    chk(result === 40'h7F_FF80_0000, "R8 old T used", result, 40'h7F_FF80_0000);
  endtask

  task automatic t_latency();
    data_in = 40'h00_0000_0001; imm_cnt = 6'd8; cnt_sel = 2'b00;
    @(posedge clk);
    #1 data_in = 40'h00_0000_0002;
    @(negedge clk);
    chk(result === 40'h00_0000_0100, "R8 latency", result, 40'h00_0000_0100);
    step();
    chk(result === 40'h00_0000_0200, "R8 next", result, 40'h00_0000_0200);
  endtask

  initial begin
    t_reset();
    t_left();
    t_right();
    t_clamp();
    t_sources();
    t_exponent();
    t_tstore();
    t_latency();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule